// File: doc/BRIEF.md
# Buffered SPI Master Shifter

This block is an SPI master with a one-entry holding register in front of its shift register. A host writes a byte into the holding register. When the shifter is idle, that byte moves into the shifter on the next clock. While a byte is still shifting out, the host can queue the following byte, and it starts at the very clock on which the current byte finishes. Each transmitted byte is also a received byte: the MISO bits captured during the transfer are latched for the host when the last clock edge of the byte has passed. The block does not drive a chip select; the host frames transfers itself.

The host has three separate indications. `tx_ready` reports that the holding register can take a byte. `rx_done` is a sticky per-byte completion flag. `busy` covers both a byte in the shifter and a byte waiting in the holding register. `tx_ready` rises when a byte leaves the holding register, not when that byte has finished. For this reason, only `rx_done` (cleared before the byte) or `busy` falling tells the host that it is safe to release chip select. The SCLK idle level, the capture edge, the bit order and an even clock divisor can all be configured. A synchronous soft reset returns the block to idle.

Top module: `spi_dbuf_master`

## Requirements
- R1: A write (`wr_en` high at a clock edge) is accepted only when `tx_ready` is 1 in that cycle. After an accepted write, `tx_ready` is 0 and `busy` is 1. If the shifter is idle, the byte enters the shifter on the next edge and `tx_ready` returns to 1.
- R2: `tx_ready` stays 0 while a queued byte waits behind a byte that is still shifting. It rises on the same edge where the shifting byte completes and the queued byte takes its place.
- R3: A queued byte starts with no idle clock between bytes, and `busy` stays 1 across the boundary. `busy` falls on the completion edge of the last byte.
- R4: On the completion edge of each byte, `rx_done` sets and `rx_data` takes the eight captured MISO bits. `rx_done` stays set until `rx_clr` is asserted. If a clear and a completion fall on the same edge, the completion wins.
- R5: `busy` is 1 whenever the shifter is active or the holding register is full. `busy` is 0 after reset.
- R6: With `lsb_first` at 0, bit 7 is the first bit on MOSI and the first MISO bit lands in bit 7 of `rx_data`. With `lsb_first` at 1, bit 0 goes first and the first MISO bit lands in bit 0.
- R7: With `cpha` at 0, both sides capture on the odd SCLK edges of a byte (edges 1, 3, …, 15) and data changes on the even ones. With `cpha` at 1, capture happens on the even edges (2 … 16) and data changes on the odd edges after the first.
- R8: When no byte is in flight, SCLK rests at the `cpol` level. Each SCLK half period lasts `half_div` system clocks, with 0 treated as 1. A byte takes exactly 16 × half period clocks, from the edge that loads it to its completion edge.
- R9: `soft_rst` stops any transfer, empties the holding register, sets `tx_ready`, clears `rx_done` and `wr_err`, and puts SCLK at its idle level. A queued byte is dropped and is never sent.
- R10: A write while `tx_ready` is 0 is ignored: the byte is not sent and the queued byte is kept. The write sets `wr_err`, which stays set until `err_clr` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| cpol | input | 1 | SCLK idle level |
| cpha | input | 1 | 0: capture on odd edges, 1: capture on even edges |
| lsb_first | input | 1 | 1: least significant bit first |
| half_div | input | DIV_W | SCLK half period in system clocks (0 acts as 1) |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Byte to transmit |
| rx_clr | input | 1 | Clears `rx_done` |
| err_clr | input | 1 | Clears `wr_err` |
| tx_ready | output | 1 | Holding register empty |
| busy | output | 1 | Byte shifting or queued |
| rx_done | output | 1 | Sticky byte-complete flag |
| rx_data | output | DATA_W | Last received byte |
| wr_err | output | 1 | Sticky write-while-full error |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
All results are counted from the write edge W. `tx_ready` falls after W and returns after W+1. With h the effective half period, a lone byte keeps `busy` at 1 through W+16h and shows `rx_done`, `rx_data` and `busy` at 0 after W+1+16h. A byte queued at W+2 completes at W+1+32h. The bench drives inputs and samples outputs at falling clock edges, and it steps an exact number of cycles to the sample point just before and just after each due edge. The slave model acts one falling edge after each SCLK transition, using the MOSI value from before that transition, so its captured bytes are read one cycle after completion.

// File: rtl/spi_dbuf_master.sv
module spi_dbuf_master #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic [DIV_W-1:0]  half_div,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rx_clr,
  input  logic              err_clr,
  output logic              tx_ready,
  output logic              busy,
  output logic              rx_done,
  output logic [DATA_W-1:0] rx_data,
  output logic              wr_err,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  localparam int EDGES = 2 * DATA_W;
  localparam int EW    = $clog2(EDGES + 1);

  logic              hold_full, active, lvl;
  logic [DATA_W-1:0] hold_q, tx_sh, rx_sh, rx_next;
  logic [DIV_W-1:0]  cnt, half_eff;
  logic [EW-1:0]     ecnt, e_num;
  logic              tick, lead, samp, shft, last, accept, load;

  assign half_eff = (half_div == '0) ? DIV_W'(1) : half_div;
  assign tick     = active && (cnt == half_eff - DIV_W'(1));
  assign e_num    = ecnt + EW'(1);
  assign lead     = e_num[0];
  assign samp     = tick && (lead ^ cpha);
  assign shft     = tick && !(lead ^ cpha) && (e_num != EW'(1)) && (e_num != EW'(EDGES));
  assign last     = tick && (e_num == EW'(EDGES));
  assign accept   = wr_en && !hold_full;
  assign load     = hold_full && (!active || last);
  assign rx_next  = lsb_first ? {miso, rx_sh[DATA_W-1:1]} : {rx_sh[DATA_W-2:0], miso};

  assign tx_ready = !hold_full;
  assign busy     = active || hold_full;
  assign sclk     = cpol ^ lvl;
  assign mosi     = lsb_first ? tx_sh[0] : tx_sh[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_q    <= '0;
      tx_sh     <= '0;
      rx_sh     <= '0;
      rx_data   <= '0;
      rx_done   <= 1'b0;
      wr_err    <= 1'b0;
      active    <= 1'b0;
      lvl       <= 1'b0;
      cnt       <= '0;
      ecnt      <= '0;
    end else if (soft_rst) begin
      hold_full <= 1'b0;
      rx_done   <= 1'b0;
      wr_err    <= 1'b0;
      active    <= 1'b0;
      lvl       <= 1'b0;
      cnt       <= '0;
      ecnt      <= '0;
    end else begin
      if (accept) begin
        hold_q    <= wr_data;
        hold_full <= 1'b1;
      end

      if (wr_en && hold_full) wr_err <= 1'b1;
      else if (err_clr)       wr_err <= 1'b0;

      if (tick) begin
        cnt  <= '0;
        lvl  <= ~lvl;
        ecnt <= e_num;
      end else if (active) begin
        cnt <= cnt + DIV_W'(1);
      end

      if (samp) rx_sh <= rx_next;
      if (shft) tx_sh <= lsb_first ? (tx_sh >> 1) : (tx_sh << 1);

      if (last) begin
        rx_data <= samp ? rx_next : rx_sh;
        rx_done <= 1'b1;
        active  <= 1'b0;
        ecnt    <= '0;
      end else if (rx_clr) begin
        rx_done <= 1'b0;
      end

      if (load) begin
        tx_sh     <= hold_q;
        hold_full <= 1'b0;
        active    <= 1'b1;
        cnt       <= '0;
        ecnt      <= '0;
      end
    end
  end
endmodule

// File: rtl/spi_dbuf_master_chk.sv
module spi_dbuf_master_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic              cpol,
  input logic              wr_en,
  input logic              rx_clr,
  input logic              err_clr,
  input logic              tx_ready,
  input logic              busy,
  input logic              rx_done,
  input logic [DATA_W-1:0] rx_data,
  input logic              wr_err,
  input logic              sclk
);
  a_r1_write_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && tx_ready && !soft_rst) |=> (!tx_ready && busy));

  a_r2_ready_means_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_ready) && !$past(soft_rst)) |-> busy);

  a_r5_queued_is_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_ready |-> busy);

  a_r4_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !rx_clr && !soft_rst) |=> rx_done);

  a_r4_data_held_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(rx_data));

  a_r8_sclk_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && $stable(cpol)) |-> $stable(sclk));

  a_r9_soft_idle: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (tx_ready && !busy && !rx_done && !wr_err));

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_err && !err_clr && !soft_rst) |=> wr_err);

  a_r10_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_err) |-> $past(wr_en && !tx_ready));
endmodule

bind spi_dbuf_master spi_dbuf_master_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cpol(cpol),
  .wr_en(wr_en), .rx_clr(rx_clr), .err_clr(err_clr),
  .tx_ready(tx_ready), .busy(busy), .rx_done(rx_done),
  .rx_data(rx_data), .wr_err(wr_err), .sclk(sclk)
);

// File: tb/spi_dbuf_master_test.sv
module spi_dbuf_master_test;
  logic clk = 0, rst_n = 0, soft_rst = 0;
  logic cpol = 0, cpha = 0, lsb_first = 0;
  logic [7:0] half_div = 8'd2;
  logic wr_en = 0, rx_clr = 0, err_clr = 0, miso = 0;
  logic [7:0] wr_data = 0;
  wire tx_ready, busy, rx_done, wr_err, sclk, mosi;
  wire [7:0] rx_data;

  spi_dbuf_master uut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cpol(cpol), .cpha(cpha),
    .lsb_first(lsb_first), .half_div(half_div), .wr_en(wr_en), .wr_data(wr_data),
    .rx_clr(rx_clr), .err_clr(err_clr), .tx_ready(tx_ready), .busy(busy),
    .rx_done(rx_done), .rx_data(rx_data), .wr_err(wr_err), .sclk(sclk),
    .mosi(mosi), .miso(miso)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // slave model, acts one falling clock edge after each SCLK transition
  logic [7:0] sq[4];
  logic [7:0] got[4];
  logic [7:0] s_cur, s_rx;
  int qi, gi, ecnt, sc, e_n;
  logic sclk_p = 0, mosi_p = 0, busy_p = 0;
  bit lead, smp;

  function automatic bit bitof(input logic [7:0] b, input int k);
    return lsb_first ? b[k] : b[7-k];
  endfunction

  always @(negedge clk) begin
    if (!rst_n || soft_rst) begin
      ecnt = 0;
      sc = 0;
    end else if (busy_p && sclk !== sclk_p) begin
      e_n  = ecnt + 1;
      lead = (e_n % 2) == 1;
      smp  = cpha ? !lead : lead;
      if (smp) begin
        s_rx[lsb_first ? sc : 7 - sc] = mosi_p;
        sc++;
      end else if (sc < 8) begin
        miso = bitof(s_cur, sc);
      end
      ecnt = e_n;
      if (ecnt == 16) begin
        got[gi % 4] = s_rx;
        gi++;
        qi++;
        s_cur = sq[qi % 4];
        if (!cpha) miso = bitof(s_cur, 0);
        ecnt = 0;
        sc = 0;
      end
    end
    sclk_p = sclk;
    mosi_p = mosi;
    busy_p = busy;
  end

  task automatic slv_load(input logic [7:0] b0, input logic [7:0] b1);
    sq[0] = b0; sq[1] = b1; sq[2] = 8'h00; sq[3] = 8'h00;
    qi = 0; gi = 0; ecnt = 0; sc = 0;
    got[0] = 8'hxx; got[1] = 8'hxx;
    s_cur = b0;
    miso = bitof(b0, 0);
  endtask

  task automatic set_cfg(input logic pol, input logic pha, input logic lsb, input logic [7:0] hd);
    @(negedge clk);
    cpol = pol; cpha = pha; lsb_first = lsb; half_div = hd;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic t_reset;
    chk("R8 sclk idle after reset", sclk, 0);
    chk("R1 tx_ready after reset", tx_ready, 1);
    chk("R5 busy after reset", busy, 0);
    chk("R4 rx_done after reset", rx_done, 0);
    chk("R10 wr_err after reset", wr_err, 0);
  endtask

  task automatic t_single;
    set_cfg(0, 0, 0, 8'd2);
    slv_load(8'h3C, 8'h00);
    wr(8'hA5);
    chk("R1 tx_ready low after write", tx_ready, 0);
    chk("R5 busy with byte queued", busy, 1);
    @(negedge clk);
    chk("R1 tx_ready back after load", tx_ready, 1);
    chk("R5 busy while shifting", busy, 1);
    repeat (31) @(negedge clk);
    chk("R8 busy before last edge", busy, 1);
    chk("R4 rx_done not early", rx_done, 0);
    @(negedge clk);
    chk("R8 busy ends after 16 half periods", busy, 0);
    chk("R4 rx_done on completion", rx_done, 1);
    chk("R4 rx_data msb first", rx_data, 8'h3C);
    @(negedge clk);
    chk("R6 slave got msb-first byte", got[0], 8'hA5);
    chk("R8 sclk back to idle", sclk, 0);
    repeat (5) @(negedge clk);
    chk("R4 rx_done sticky", rx_done, 1);
    rx_clr = 1;
    @(negedge clk);
    rx_clr = 0;
    chk("R4 rx_clr clears flag", rx_done, 0);
  endtask

  task automatic t_b2b;
    set_cfg(0, 0, 0, 8'd2);
    slv_load(8'h11, 8'h22);
    wr(8'hC3);                       // N0
    @(negedge clk);                  // N1
    wr_en = 1; wr_data = 8'h5A;
    @(negedge clk);                  // N2
    chk("R2 tx_ready low with byte queued", tx_ready, 0);
    wr_data = 8'hFF;                 // write while full
    @(negedge clk);                  // N3
    wr_en = 0;
    chk("R10 wr_err on write while full", wr_err, 1);
    repeat (29) @(negedge clk);      // N32
    chk("R2 tx_ready stays low until first byte done", tx_ready, 0);
    chk("R4 no completion yet", rx_done, 0);
    @(negedge clk);                  // N33
    chk("R2 tx_ready rises at completion", tx_ready, 1);
    chk("R4 first byte done", rx_done, 1);
    chk("R3 busy across byte boundary", busy, 1);
    chk("R4 first rx byte", rx_data, 8'h11);
    repeat (31) @(negedge clk);      // N64
    chk("R3 second byte still in flight", busy, 1);
    rx_clr = 1;
    @(negedge clk);                  // N65
    rx_clr = 0;
    chk("R4 completion wins over clear", rx_done, 1);
    chk("R4 second rx byte", rx_data, 8'h22);
    chk("R3 busy falls after last byte", busy, 0);
    @(negedge clk);
    chk("R3 slave byte 0", got[0], 8'hC3);
    chk("R10 queued byte kept over ignored write", got[1], 8'h5A);
    repeat (20) @(negedge clk);
    chk("R10 ignored byte never sent", gi, 2);
    chk("R10 wr_err sticky", wr_err, 1);
    err_clr = 1;
    @(negedge clk);
    err_clr = 0;
    chk("R10 err_clr clears", wr_err, 0);
    rx_clr = 1;
    @(negedge clk);
    rx_clr = 0;
  endtask

  task automatic t_mode(input logic pol, input logic pha, input logic lsb, input logic [7:0] hd,
                        input logic [7:0] tx, input logic [7:0] rxb);
    int h;
    h = (hd == 0) ? 1 : int'(hd);
    set_cfg(pol, pha, lsb, hd);
    chk("R8 sclk idles at cpol", sclk, pol);
    slv_load(rxb, 8'h00);
    wr(tx);
    @(negedge clk);
    repeat (16 * h - 1) @(negedge clk);
    chk("R8 busy through whole byte", busy, 1);
    @(negedge clk);
    chk("R8 byte length 16 half periods", busy, 0);
    chk("R7 rx_data with this phase", rx_data, rxb);
    chk("R4 rx_done set", rx_done, 1);
    @(negedge clk);
    chk("R7 slave captured byte", got[0], tx);
    chk("R6 order honoured, sclk idle", sclk, pol);
  endtask

  task automatic t_soft;
    set_cfg(0, 0, 0, 8'd4);
    slv_load(8'h77, 8'h88);
    wr(8'hA1);                       // N0
    @(negedge clk);
    wr_en = 1; wr_data = 8'hB2;
    @(negedge clk);
    wr_data = 8'hC4;
    @(negedge clk);
    wr_en = 0;
    chk("R10 error before soft reset", wr_err, 1);
    repeat (3) @(negedge clk);
    soft_rst = 1;
    @(negedge clk);
    soft_rst = 0;
    chk("R9 tx_ready after soft reset", tx_ready, 1);
    chk("R9 busy cleared", busy, 0);
    chk("R9 rx_done cleared", rx_done, 0);
    chk("R9 wr_err cleared", wr_err, 0);
    chk("R9 sclk idle", sclk, 0);
    repeat (40) @(negedge clk);
    chk("R9 queued byte dropped", busy, 0);
    chk("R9 nothing completed", rx_done, 0);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_b2b();
    t_mode(1, 1, 1, 8'd0, 8'h96, 8'h4E);
    t_mode(0, 1, 0, 8'd3, 8'h0F, 8'hD2);
    t_mode(1, 0, 1, 8'd1, 8'h81, 8'h35);
    t_soft();
    t_mode(0, 0, 0, 8'd2, 8'h6B, 8'hE1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule